// File: doc/BRIEF.md
# Divider-Tapped Programmable Timer

This block keeps a free-running 16-bit divider that advances once per `tickIn` pulse, and an 8-bit counter that steps whenever a chosen divider bit, gated by an enable, falls from 1 to 0. Software reaches four byte-wide registers through one select field: the divider (upper byte on read, cleared by any write), the counter, the modulo value and a 3-bit control word.

When the counter wraps with the enable set, it holds zero for a short window and then loads the modulo value, raising a one-cycle interrupt pulse. A counter write during that window cancels the load. For a few ticks after a load, counter writes are dropped, and a modulo write is copied straight into the counter. If the enable is clear when the counter wraps, the interrupt fires at once and no load follows.

Register selects on `regSel`: 0 = divider, 1 = counter, 2 = modulo, 3 = control. One clock cycle applies the register write first. If `tickIn` is high, the tick logic then runs on the written values.

Top module: `tap_timer`

## Requirements
- R1: The divider adds 1 on every cycle with `tickIn` high. Reading select 0 returns divider bits 15:8. Any write to select 0 clears the whole divider.
- R2: Only control bits 2:0 are stored. A read of select 3 returns bits 7:3 as 1. Bit 2 is the enable. Bits 1:0 choose the divider tap: 0 gives bit 9, 1 gives bit 3, 2 gives bit 5 and 3 gives bit 7.
- R3: The counter adds 1 on a tick where (tap AND enable) was 1 after the previous tick and is 0 now. Clearing the divider, or dropping the enable, while the tap is high therefore produces one extra increment on the next tick.
- R4: If the counter wraps from 0xFF with the enable set, it reads 0x00 for the next three ticks. On the fourth tick after the wrap it takes the modulo value, and `irqPulse` is high for exactly the cycle after that edge.
- R5: A counter write accepted between the wrap and the load cancels the load. The written value stays and no interrupt is raised.
- R6: For four ticks after a load, writes to the counter are ignored. A modulo write in that window also loads the written byte into the counter. After the window, counter writes take effect again.
- R7: If the counter wraps while the enable is clear, `irqPulse` goes high in the cycle after that edge. No delayed load follows.
- R8: After reset the divider holds 8 (select 0 reads 0x00, and it reads 0x01 after 248 ticks). The counter and modulo read 0x00, control reads 0xF8, and `irqPulse` is low.
- R9: In one cycle a register write is applied before the tick logic runs. For example, writing 0xFF to the counter on the tick that produces a falling edge leaves the counter at 0x00.
- R10: Without `tickIn`, the divider and the counter do not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickIn | input | 1 | Single-cycle tick enable |
| wrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select for both read and write |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the selected register (combinational) |
| irqPulse | output | 1 | One-cycle interrupt request |

## Verification
The hardest states to reach are the short windows around a wrap: the three-tick gap before the load, and the four-tick window after it where writes are dropped or redirected. The stimulus first writes 0xFF into the counter. It then selects the fastest tap and issues exactly the number of ticks that brings the divider from its reset value of 8 to the next falling edge of bit 3. After that it steps one tick at a time and places writes into the windows at known offsets. Spurious increments are reached by raising the tap with a single tick and then clearing the divider or the enable without a tick.

// File: rtl/tap_timer_pkg.sv
package tap_timer_pkg;

  typedef enum logic [1:0] {
    SEL_DIV = 2'd0,
    SEL_CNT = 2'd1,
    SEL_MOD = 2'd2,
    SEL_CTL = 2'd3
  } regSel_e;

  // strobes from control to datapath, all for the current cycle
  typedef struct packed {
    logic tick;        // tick logic runs this cycle
    logic clrDiv;      // divider write
    logic wrCtl;       // control write
    logic wrMod;       // modulo write
    logic cntLoadBus;  // counter takes wrData (accepted write or modulo copy)
    logic reload;      // delayed load from modulo fires
  } tmrStrobe_t;

endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import tap_timer_pkg::*;
#(
  parameter int RELOAD_DELAY = 4,
  parameter int IGNORE_LEN   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickIn,
  input  logic       wrEn,
  input  logic [1:0] wrSel,
  input  logic       overflow,
  input  logic       enNext,
  output tmrStrobe_t stb,
  output logic       irqPulse
);

  localparam int PW = $clog2(RELOAD_DELAY + 1);
  localparam int IW = $clog2(IGNORE_LEN + 1);

  logic [PW-1:0] pendCnt, pendNext;
  logic [IW-1:0] ignoreCnt, ignoreNext;
  logic          reloadBlock, blockNext;
  logic          coinc, coincNext;
  logic          irqQ;

  logic hitCnt, acceptCnt, copyMod, blockEff, pendExpire;

  always_comb begin
    hitCnt     = wrEn && (wrSel == SEL_CNT);
    acceptCnt  = hitCnt && (ignoreCnt == '0);
    copyMod    = wrEn && (wrSel == SEL_MOD) && coinc;
    blockEff   = reloadBlock || acceptCnt;
    pendExpire = tickIn && (pendCnt == PW'(1));

    stb.tick       = tickIn;
    stb.clrDiv     = wrEn && (wrSel == SEL_DIV);
    stb.wrCtl      = wrEn && (wrSel == SEL_CTL);
    stb.wrMod      = wrEn && (wrSel == SEL_MOD);
    stb.cntLoadBus = acceptCnt || copyMod;
    stb.reload     = pendExpire && !blockEff;
  end

  always_comb begin
    ignoreNext = ignoreCnt;
    coincNext  = coinc;
    pendNext   = pendCnt;
    blockNext  = blockEff;
    if (tickIn && ignoreCnt != '0) begin
      ignoreNext = ignoreCnt - IW'(1);
      if (ignoreCnt == IW'(1)) coincNext = 1'b0;
    end
    if (tickIn && pendCnt != '0) pendNext = pendCnt - PW'(1);
    if (stb.reload) begin
      ignoreNext = IW'(IGNORE_LEN);
      coincNext  = 1'b1;
    end
    if (overflow && enNext) begin
      pendNext  = PW'(RELOAD_DELAY);
      blockNext = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCnt     <= '0;
      ignoreCnt   <= '0;
      reloadBlock <= 1'b0;
      coinc       <= 1'b0;
      irqQ        <= 1'b0;
    end else begin
      pendCnt     <= pendNext;
      ignoreCnt   <= ignoreNext;
      reloadBlock <= blockNext;
      coinc       <= coincNext;
      irqQ        <= stb.reload || (overflow && !enNext);
    end
  end

  assign irqPulse = irqQ;

  // R4: a load is followed by the interrupt pulse
  a_r4_reload_irq: assert property (@(posedge clk) disable iff (!rstN)
    stb.reload |=> irqPulse);
  // R6: a load opens the full write-ignore window
  a_r6_ignore_open: assert property (@(posedge clk) disable iff (!rstN)
    stb.reload |=> (ignoreCnt == IW'(IGNORE_LEN)));
  // R4: an enabled wrap arms the delayed load
  a_r4_pend_armed: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && enNext) |=> (pendCnt == PW'(RELOAD_DELAY)));
  // R7: a disabled wrap raises the interrupt at once
  a_r7_direct_irq: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !enNext) |=> irqPulse);
  // R10: without a tick the windows do not move
  a_r10_hold_windows: assert property (@(posedge clk) disable iff (!rstN)
    (!tickIn && !overflow) |=> $stable(pendCnt));

endmodule

// File: rtl/timer_dp.sv
module timer_dp
  import tap_timer_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int DATA_W    = 8,
  parameter int RESET_DIV = 8,
  parameter int TAP_SEL0  = 9,
  parameter int TAP_SEL1  = 3,
  parameter int TAP_SEL2  = 5,
  parameter int TAP_SEL3  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic              overflow,
  output logic              enNext
);

  localparam int CTL_W   = 3;
  localparam int N_TAPS  = 4;
  localparam int EN_BIT  = 2;

  function automatic int tapPos(input int s);
    case (s)
      0:       return TAP_SEL0;
      1:       return TAP_SEL1;
      2:       return TAP_SEL2;
      default: return TAP_SEL3;
    endcase
  endfunction

  logic [DIV_W-1:0]  div, divW, divT;
  logic [DATA_W-1:0] cnt, cntW, cntR, cntNext;
  logic [DATA_W-1:0] mod, modW;
  logic [CTL_W-1:0]  ctl, ctlW;
  logic              oldState, stateN, fall;
  logic [N_TAPS-1:0] tapVec;

  always_comb begin
    divW = stb.clrDiv ? '0 : div;
    divT = stb.tick ? divW + DIV_W'(1) : divW;
    modW = stb.wrMod ? wrData : mod;
    ctlW = stb.wrCtl ? wrData[CTL_W-1:0] : ctl;
    cntW = stb.cntLoadBus ? wrData : cnt;
    cntR = stb.reload ? modW : cntW;
  end

  for (genvar g = 0; g < N_TAPS; g++) begin : gTap
    assign tapVec[g] = divT[tapPos(g)];
  end

  always_comb begin
    stateN   = tapVec[ctlW[1:0]] && ctlW[EN_BIT];
    fall     = stb.tick && oldState && !stateN;
    overflow = fall && (&cntR);
    cntNext  = fall ? cntR + DATA_W'(1) : cntR;
    enNext   = ctlW[EN_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      div      <= DIV_W'(RESET_DIV);
      cnt      <= '0;
      mod      <= '0;
      ctl      <= '0;
      oldState <= 1'b0;
    end else begin
      div <= divT;
      cnt <= cntNext;
      mod <= modW;
      ctl <= ctlW;
      if (stb.tick) oldState <= stateN;
    end
  end

  always_comb begin
    case (rdSel)
      SEL_DIV: rdData = div[DIV_W-1 -: DATA_W];
      SEL_CNT: rdData = cnt;
      SEL_MOD: rdData = mod;
      default: rdData = {{(DATA_W-CTL_W){1'b1}}, ctl};
    endcase
  end

  // R2: unused control bits read as ones
  a_r2_ctl_high_ones: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel == SEL_CTL) |-> (&rdData[DATA_W-1:CTL_W]));
  // R1: a divider write leaves zero, or one when ticked
  a_r1_div_clear: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrDiv |=> (div == (stb.tick ? DIV_W'(1) : DIV_W'(0))));
  // R10: no tick, no divider movement
  a_r10_div_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.tick && !stb.clrDiv) |=> $stable(div));
  // R4: an enabled wrap leaves the counter at zero
  a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> (cnt == '0));

endmodule

// File: rtl/tap_timer.sv
module tap_timer
  import tap_timer_pkg::*;
#(
  parameter int DIV_W        = 16,
  parameter int DATA_W       = 8,
  parameter int RESET_DIV    = 8,
  parameter int RELOAD_DELAY = 4,
  parameter int IGNORE_LEN   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              wrEn,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqPulse
);

  tmrStrobe_t stb;
  logic       overflow, enNext;

  timer_ctrl #(
    .RELOAD_DELAY(RELOAD_DELAY),
    .IGNORE_LEN  (IGNORE_LEN)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .tickIn  (tickIn),
    .wrEn    (wrEn),
    .wrSel   (regSel),
    .overflow(overflow),
    .enNext  (enNext),
    .stb     (stb),
    .irqPulse(irqPulse)
  );

  timer_dp #(
    .DIV_W    (DIV_W),
    .DATA_W   (DATA_W),
    .RESET_DIV(RESET_DIV)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (wrData),
    .rdSel   (regSel),
    .rdData  (rdData),
    .overflow(overflow),
    .enNext  (enNext)
  );

endmodule

// File: tb/tap_timer_test.sv
`timescale 1ns/1ps
module tap_timer_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickIn = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       irqPulse;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  tap_timer uut (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .wrEn(wrEn),
    .regSel(regSel), .wrData(wrData), .rdData(rdData), .irqPulse(irqPulse)
  );

  localparam logic [1:0] S_DIV = 2'd0, S_CNT = 2'd1, S_MOD = 2'd2, S_CTL = 2'd3;

  // {control, ticks, expected counter, expected divider high byte}
  localparam int NV = 7;
  localparam logic [39:0] VEC [NV] = '{
    {8'h05, 16'd40,   8'd3, 8'h00},  // R2 tap bit 3: edges at 16,32,48
    {8'h06, 16'd120,  8'd2, 8'h00},  // R2 tap bit 5: edges at 64,128
    {8'h07, 16'd600,  8'd2, 8'h02},  // R2 tap bit 7: edges at 256,512
    {8'h04, 16'd1100, 8'd1, 8'h04},  // R2 tap bit 9: edge at 1024
    {8'h01, 16'd40,   8'd0, 8'h00},  // R2 enable clear: no steps
    {8'h05, 16'd7,    8'd0, 8'h00},  // R3 divider 15: not yet
    {8'h05, 16'd8,    8'd1, 8'h00}   // R3 divider 16: first edge
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [1:0] s, input logic [7:0] d, input logic t);
    @(negedge clk);
    wrEn = w; regSel = s; wrData = d; tickIn = t;
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    cyc(1'b1, s, d, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, S_DIV, 8'h00, 1'b1);
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    @(negedge clk);
    wrEn = 1'b0; tickIn = 1'b0; regSel = s;
    #1;
    v = rdData;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; tickIn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic finish();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    wait (cycles > 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    finish();
  end

  initial begin
    logic [7:0] v;

    // R8 reset state
    doReset();
    rd(S_DIV, v); check("R8 divider high", v, 8'h00);
    rd(S_CNT, v); check("R8 counter", v, 8'h00);
    rd(S_MOD, v); check("R8 modulo", v, 8'h00);
    rd(S_CTL, v); check("R8 control", v, 8'hF8);
    check("R8 irq", {7'd0, irqPulse}, 8'h00);
    ticks(247);
    rd(S_DIV, v); check("R8 divider 255", v, 8'h00);
    ticks(1);
    rd(S_DIV, v); check("R8 R1 divider 256", v, 8'h01);
    wr(S_DIV, 8'h5A);
    rd(S_DIV, v); check("R1 divider cleared", v, 8'h00);

    // R2 control masking
    wr(S_CTL, 8'hFF);
    rd(S_CTL, v); check("R2 control all", v, 8'hFF);
    wr(S_CTL, 8'h00);
    rd(S_CTL, v); check("R2 control none", v, 8'hF8);

    // R2 tap table walk
    for (int k = 0; k < NV; k++) begin
      doReset();
      wr(S_CTL, VEC[k][39:32]);
      ticks(int'(VEC[k][31:16]));
      rd(S_CNT, v); check($sformatf("R2 vector %0d counter", k), v, VEC[k][15:8]);
      rd(S_DIV, v); check($sformatf("R1 vector %0d divider", k), v, VEC[k][7:0]);
    end

    // R3 spurious step from divider clear, R10 hold without tick
    doReset();
    wr(S_CTL, 8'h05);
    ticks(1);
    wr(S_DIV, 8'h00);
    for (int i = 0; i < 20; i++) cyc(1'b0, S_CNT, 8'h00, 1'b0);
    rd(S_CNT, v); check("R10 counter hold", v, 8'h00);
    ticks(1);
    rd(S_CNT, v); check("R3 divider clear step", v, 8'h01);

    // R3 spurious step from enable drop
    doReset();
    wr(S_CTL, 8'h05);
    ticks(1);
    wr(S_CTL, 8'h01);
    ticks(1);
    rd(S_CNT, v); check("R3 enable drop step", v, 8'h01);

    // R4 delayed load, R6 ignore window
    doReset();
    wr(S_MOD, 8'hA5);
    wr(S_CNT, 8'hFF);
    wr(S_CTL, 8'h05);
    ticks(8);
    check("R4 no irq at wrap", {7'd0, irqPulse}, 8'h00);
    rd(S_CNT, v); check("R4 wrapped", v, 8'h00);
    for (int i = 0; i < 3; i++) begin
      ticks(1);
      check("R4 no early irq", {7'd0, irqPulse}, 8'h00);
    end
    rd(S_CNT, v); check("R4 held zero", v, 8'h00);
    ticks(1);
    check("R4 irq on load", {7'd0, irqPulse}, 8'h01);
    rd(S_CNT, v); check("R4 loaded", v, 8'hA5);
    cyc(1'b0, S_CNT, 8'h00, 1'b0);
    check("R4 irq one cycle", {7'd0, irqPulse}, 8'h00);
    wr(S_CNT, 8'h11);
    rd(S_CNT, v); check("R6 write ignored", v, 8'hA5);
    wr(S_MOD, 8'h3C);
    rd(S_CNT, v); check("R6 modulo copy", v, 8'h3C);
    ticks(4);
    wr(S_CNT, 8'h11);
    rd(S_CNT, v); check("R6 window closed", v, 8'h11);

    // R5 cancel by counter write
    doReset();
    wr(S_MOD, 8'h77);
    wr(S_CNT, 8'hFF);
    wr(S_CTL, 8'h05);
    ticks(9);
    wr(S_CNT, 8'h42);
    for (int i = 0; i < 5; i++) begin
      ticks(1);
      check("R5 no irq", {7'd0, irqPulse}, 8'h00);
    end
    rd(S_CNT, v); check("R5 value kept", v, 8'h42);

    // R7 wrap with enable clear
    doReset();
    wr(S_MOD, 8'h99);
    wr(S_CNT, 8'hFF);
    wr(S_CTL, 8'h05);
    ticks(1);
    wr(S_CTL, 8'h01);
    ticks(1);
    check("R7 immediate irq", {7'd0, irqPulse}, 8'h01);
    rd(S_CNT, v); check("R7 wrapped", v, 8'h00);
    for (int i = 0; i < 5; i++) begin
      ticks(1);
      check("R7 no later irq", {7'd0, irqPulse}, 8'h00);
    end
    rd(S_CNT, v); check("R7 no load", v, 8'h00);

    // R9 write before tick in the same cycle
    doReset();
    wr(S_CTL, 8'h05);
    ticks(7);
    cyc(1'b1, S_CNT, 8'hFF, 1'b1);
    rd(S_CNT, v); check("R9 write then tick", v, 8'h00);

    finish();
  end

endmodule